// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog made of two down-counting stages. A low stage decrements on every clock and signals an underflow each time it wraps. A high stage decrements on each pulse from a selectable count source. That source is either the low stage's underflow or a tick from a free-running clock divider. When the high stage runs out, the block raises a one-cycle system reset request and then carries on counting from all ones.

Software keeps the system alive by writing the control register. Any write restarts both stages and the divider. The same write picks the high stage's count source and may set a sticky bit that forbids stop mode. The upper bits of the high stage can be read back so that firmware can see how much time is left.

Top module: `wdog2`

## Requirements
- R1: After reset `rst_req_o` is 0, `stop_ok_o` is 1 and `hi_rd_o` is all ones.
- R2: With the source bit clear (`wr_src_fast_i` = 0 at the last write, or no write since reset), the first reset request rises exactly 2^LO_W * 2^HI_W clock cycles after the write edge or after the last reset cycle.
- R3: With the source bit set (`wr_src_fast_i` = 1), the high stage steps once every 2^DIV_LOG2 cycles, and the first reset request comes exactly 2^DIV_LOG2 * 2^HI_W cycles after the write edge.
- R4: The reset request lasts one cycle and leaves the high stage at all ones. With no write, further requests repeat at the same period.
- R5: A write with `wr_en_i` = 1 restarts the low stage, the high stage and the divider. In the cycle after the write `hi_rd_o` is all ones, and the next request is timed from that write.
- R6: `hi_rd_o` shows the top RD_W bits of the high stage. Counted in cycles t after a write, the high stage holds 2^HI_W - 1 - floor(t / step), where step is 2^LO_W (slow source) or 2^DIV_LOG2 (fast source).
- R7: A write with `wr_stop_dis_i` = 1 drives `stop_ok_o` to 0 from the next cycle on. A later write with `wr_stop_dis_i` = 0 leaves it at 0.
- R8: Reset, and only reset, returns `stop_ok_o` to 1 and selects the slow source again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe; restarts both stages |
| wr_src_fast_i | input | 1 | Written source bit: 1 = divided clock, 0 = low-stage underflow |
| wr_stop_dis_i | input | 1 | Written stop-disable bit; a 1 sticks until reset |
| rst_req_o | output | 1 | One-cycle system reset request |
| stop_ok_o | output | 1 | 1 while entering stop mode is allowed |
| hi_rd_o | output | RD_W | Top RD_W bits of the high stage |

## Verification
The bench builds the block with LO_W = 4, HI_W = 7, RD_W = 6 and DIV_LOG2 = 2. This gives periods of 2048 cycles on the slow source and 512 cycles on the fast one. At these sizes both sources run out several times in one run, including back-to-back expiries. The settings also make the readback drop one bit below the stage width, so a wrong bit slice shows up at intermediate counts.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;
  typedef struct packed {
    logic src_fast;  // 1: divided clock drives high stage
    logic stop_dis;  // sticky until reset
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog2_lo_stage.sv
module wdog2_lo_stage #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic uf_o
);
  logic [W-1:0] cnt_q;

  // wrap from zero reloads all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '1;
    else if (restart_i) cnt_q <= '1;
    else                cnt_q <= cnt_q - 1'b1;
  end

  assign uf_o = (cnt_q == '0);
endmodule

// File: rtl/wdog2_prescaler.sv
module wdog2_prescaler #(
  parameter int DIV_LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (DIV_LOG2 > 0) ? DIV_LOG2 : 1;

  generate
    if (DIV_LOG2 == 0) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == '1);
    end
  endgenerate
endmodule

// File: rtl/wdog2_hi_stage.sv
module wdog2_hi_stage #(
  parameter int W    = 8,
  parameter int RD_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            adv_i,
  output logic            expire_o,
  output logic [RD_W-1:0] rd_o
);
  logic [W-1:0] cnt_q;
  logic         exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      exp_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '1;
      exp_q <= 1'b0;
    end else if (adv_i) begin
      cnt_q <= cnt_q - 1'b1;
      exp_q <= (cnt_q == '0);
    end else begin
      exp_q <= 1'b0;
    end
  end

  assign expire_o = exp_q;
  assign rd_o     = cnt_q[W-1 -: RD_W];
endmodule

// File: rtl/wdog2.sv
module wdog2 #(
  parameter int LO_W     = 8,
  parameter int HI_W     = 8,
  parameter int RD_W     = 6,
  parameter int DIV_LOG2 = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_src_fast_i,
  input  logic            wr_stop_dis_i,
  output logic            rst_req_o,
  output logic            stop_ok_o,
  output logic [RD_W-1:0] hi_rd_o
);
  import wdog2_pkg::*;

  wdog_ctrl_t ctrl_q;
  logic       lo_uf, div_tick, hi_adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q.src_fast <= wr_src_fast_i;
      ctrl_q.stop_dis <= ctrl_q.stop_dis | wr_stop_dis_i;
    end
  end

  wdog2_lo_stage #(.W(LO_W)) u_lo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_en_i),
    .uf_o      (lo_uf)
  );

  wdog2_prescaler #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_en_i),
    .tick_o    (div_tick)
  );

  assign hi_adv = ctrl_q.src_fast ? div_tick : lo_uf;

  wdog2_hi_stage #(.W(HI_W), .RD_W(RD_W)) u_hi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_en_i),
    .adv_i     (hi_adv),
    .expire_o  (rst_req_o),
    .rd_o      (hi_rd_o)
  );

  assign stop_ok_o = ~ctrl_q.stop_dis;
endmodule

module wdog2_chk #(
  parameter int RD_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            wr_stop_dis_i,
  input logic            rst_req_o,
  input logic            stop_ok_o,
  input logic [RD_W-1:0] hi_rd_o
);
  // R4
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R4
  a_r4_reload_on_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (hi_rd_o == {RD_W{1'b1}}));
  // R5
  a_r5_write_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (hi_rd_o == {RD_W{1'b1}}) && !rst_req_o);
  // R7
  a_r7_stop_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_stop_dis_i) |=> !stop_ok_o);
  // R7
  a_r7_stop_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_ok_o |=> !stop_ok_o);
endmodule

bind wdog2 wdog2_chk #(.RD_W(RD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_stop_dis_i (wr_stop_dis_i),
  .rst_req_o     (rst_req_o),
  .stop_ok_o     (stop_ok_o),
  .hi_rd_o       (hi_rd_o)
);

// File: tb/wdog2_tb.sv
`timescale 1ns/1ps
module wdog2_tb;
  localparam int LO_W = 4, HI_W = 7, RD_W = 6, DIV_LOG2 = 2;
  localparam int PS = (1 << LO_W) * (1 << HI_W);
  localparam int PF = (1 << DIV_LOG2) * (1 << HI_W);
  localparam int SH = HI_W - RD_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, wr_src_fast_i = 1'b0, wr_stop_dis_i = 1'b0;
  logic rst_req_o, stop_ok_o;
  logic [RD_W-1:0] hi_rd_o;

  wdog2 #(.LO_W(LO_W), .HI_W(HI_W), .RD_W(RD_W), .DIV_LOG2(DIV_LOG2)) u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int cyc = 0, n_run = 0, n_fail = 0, cur_period = PS, wcyc = 0;
  int exp_q[$];
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (rst_req_o) begin
        if (exp_q.size() == 0) check(0, "R4 unexpected request", cyc, -1);
        else begin
          check(exp_q[0] == cyc, "R2/R3/R4 request cycle", cyc, exp_q[0]);
          void'(exp_q.pop_front());
        end
        check(hi_rd_o == {RD_W{1'b1}}, "R4 reload after expiry", hi_rd_o, (1 << RD_W) - 1);
        exp_q.push_back(cyc + cur_period);
      end else if (exp_q.size() != 0 && cyc >= exp_q[0]) begin
        check(0, "R2/R3 missed request", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_i); #1;
    rst_ni = 1'b0; exp_q.delete();
    repeat (3) @(negedge clk_i);
    #1;
    check(rst_req_o == 1'b0, "R1 request low in reset", rst_req_o, 0);
    rst_ni = 1'b1;
    cur_period = PS;
    exp_q.push_back(cyc + PS);
  endtask

  task automatic do_write(input bit fast, input bit stopd);
    @(negedge clk_i); #1;
    wr_en_i = 1'b1; wr_src_fast_i = fast; wr_stop_dis_i = stopd;
    wcyc = cyc + 1;
    cur_period = fast ? PF : PS;
    exp_q.delete();
    exp_q.push_back(wcyc + cur_period);
    @(negedge clk_i); #1;
    wr_en_i = 1'b0; wr_src_fast_i = 1'b0; wr_stop_dis_i = 1'b0;
    check(hi_rd_o == {RD_W{1'b1}}, "R5 readback after write", hi_rd_o, (1 << RD_W) - 1);
  endtask

  // readback expected t cycles after the write edge
  function automatic int exp_rd(input int t, input int step);
    return (((1 << HI_W) - 1) - t / step) >> SH;
  endfunction

  initial begin
    do_reset();
    // R1
    check(rst_req_o == 1'b0, "R1 request", rst_req_o, 0);
    check(stop_ok_o == 1'b1, "R1 stop_ok", stop_ok_o, 1);
    check(hi_rd_o == {RD_W{1'b1}}, "R1 readback", hi_rd_o, (1 << RD_W) - 1);

    // R2, R8: slow source from reset; R4: two back-to-back expiries
    repeat (2 * PS + 10) @(negedge clk_i);

    // R6 slow source readback
    do_write(1'b0, 1'b0);
    repeat (100 - (cyc - wcyc)) @(negedge clk_i);
    check(int'(hi_rd_o) == exp_rd(100, 1 << LO_W), "R6 slow readback", hi_rd_o, exp_rd(100, 1 << LO_W));
    repeat (900) @(negedge clk_i);
    check(int'(hi_rd_o) == exp_rd(cyc - wcyc, 1 << LO_W), "R6 slow readback late", hi_rd_o, exp_rd(cyc - wcyc, 1 << LO_W));

    // R5: repeated kicks hold off the request
    for (int k = 0; k < 4; k++) begin
      repeat (PS - 200) @(negedge clk_i);
      do_write(1'b0, 1'b0);
    end
    check(rst_req_o == 1'b0, "R5 no request while kicked", rst_req_o, 0);

    // R3: fast source
    do_write(1'b1, 1'b0);
    repeat (10 - (cyc - wcyc)) @(negedge clk_i);
    check(int'(hi_rd_o) == exp_rd(10, 1 << DIV_LOG2), "R3 fast readback", hi_rd_o, exp_rd(10, 1 << DIV_LOG2));
    repeat (3 * PF) @(negedge clk_i);

    // R7: stop disable is sticky
    check(stop_ok_o == 1'b1, "R7 stop_ok before set", stop_ok_o, 1);
    do_write(1'b1, 1'b1);
    check(stop_ok_o == 1'b0, "R7 stop_ok cleared", stop_ok_o, 0);
    do_write(1'b0, 1'b0);
    check(stop_ok_o == 1'b0, "R7 stop_ok sticky", stop_ok_o, 0);
    repeat (PS + 10) @(negedge clk_i);

    // R8: reset restores stop_ok and slow source
    do_write(1'b1, 1'b1);
    do_reset();
    check(stop_ok_o == 1'b1, "R8 stop_ok after reset", stop_ok_o, 1);
    repeat (PF + 40) @(negedge clk_i);
    check(int'(hi_rd_o) == exp_rd(PF + 40, 1 << LO_W), "R8 slow source after reset", hi_rd_o, exp_rd(PF + 40, 1 << LO_W));
    repeat (PS) @(negedge clk_i);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule